// File: doc/BRIEF.md
# Interrupt Cause Register with Auto-Mask

The block collects single-cycle hardware event pulses into a sticky cause register. It gates the cause bits with a per-cause enable mask and drives one level interrupt line to the host. Software reaches the block over a simple register bus with read and write strobes, a word address, write data and read data. Reading the cause word returns the pending causes and clears them. Writing the cause word clears the causes written as 1.

An auto-mask value register removes the need for a separate mask write. While the external auto-mask enable is high and the interrupt is asserted, any read or write of the cause word also clears every mask bit that is 1 in the auto-mask value. A handler can therefore silence a group of sources with the same access that acknowledges them.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset the cause bits, the mask and the auto-mask value are all zero, and irq_o is low.
- R2: A 1 on event_i[i] in a cycle sets cause bit i at that clock edge.
- R3: A read at word address 0 (cause) returns, in the strobe cycle, the cause bits in rdata_o[NUM_CAUSE-1:0], the interrupt flag in bit 31 and zeros elsewhere. The read clears all cause bits at the edge. A write at address 0 clears each cause bit written as 1.
- R4: irq_o is high exactly when some cause bit is set and its mask bit is 1. It follows the registers in the same cycle that they update.
- R5: A write at address 1 (mask set) enables each cause written as 1. A write at address 2 (mask clear) disables each cause written as 1. Bits written as 0 do not change the mask. A read at address 1 or 2 returns the mask, zero-extended.
- R6: Address 3 holds the 32-bit auto-mask value, which is written and read back in full.
- R7: A read or write at address 0 while automask_en_i=1 and irq_o=1 clears every mask bit whose auto-mask bit is 1.
- R8: A cause access with automask_en_i=0, or with irq_o=0, leaves the mask unchanged.
- R9: When an event and a clear hit the same cause bit in the same cycle, the bit stays set.
- R10: When wr_en_i and rd_en_i are both high, only the write is performed. The read strobe is ignored and does not clear any cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | NUM_CAUSE | Hardware event pulses, one per cause |
| automask_en_i | input | 1 | Global enable for the auto-mask side effect |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Summary interrupt line |

## Verification
Two functions can fall in the same cycle. One is a hardware event setting a cause bit, and the other is a bus access clearing the same bit, either by read-to-clear or by write-1-to-clear. The bench holds the event pulse high in the very cycle of the read or write strobe. It judges the result with a second read, which must still show the bit. A second overlap comes from the auto-mask side effect, which fires on the cause access itself. That case is judged by reading the mask back after accesses made with and without the enable and the asserted interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W_DEF = 4;
  localparam int unsigned OFS_CAUSE  = 0;
  localparam int unsigned OFS_MSET   = 1;
  localparam int unsigned OFS_MCLR   = 2;
  localparam int unsigned OFS_AMASK  = 3;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
  parameter int unsigned NUM_CAUSE = 31
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CAUSE-1:0] set_i,
  input  logic [NUM_CAUSE-1:0] clr_i,
  output logic [NUM_CAUSE-1:0] cause_o
);
  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_bit
    // set dominates clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_o[i] <= 1'b0;
      else         cause_o[i] <= (cause_o[i] & ~clr_i[i]) | set_i[i];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_CAUSE = 31
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CAUSE-1:0] set_i,
  input  logic [NUM_CAUSE-1:0] clr_i,
  output logic [NUM_CAUSE-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= (mask_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/irq_word_reg.sv
module irq_word_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int unsigned NUM_CAUSE = 31,
  parameter int unsigned ADDR_W    = irq_pkg::ADDR_W_DEF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CAUSE-1:0]       event_i,
  input  logic                       automask_en_i,
  input  logic                       rd_en_i,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [irq_pkg::DATA_W-1:0] wdata_i,
  output logic [irq_pkg::DATA_W-1:0] rdata_o,
  output logic                       irq_o
);
  localparam int unsigned DW = irq_pkg::DATA_W;
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(irq_pkg::OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(irq_pkg::OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(irq_pkg::OFS_MCLR);
  localparam logic [ADDR_W-1:0] A_AMASK = ADDR_W'(irq_pkg::OFS_AMASK);

  logic [NUM_CAUSE-1:0] cause_q, mask_q, cause_clr, mask_set, mask_clr;
  logic [DW-1:0]        am_q, cause_word;
  logic                 rd_ok, cause_acc, auto_fire;

  assign rd_ok     = rd_en_i & ~wr_en_i;  // write wins over read
  assign cause_acc = (rd_ok | wr_en_i) & (addr_i == A_CAUSE);
  assign auto_fire = cause_acc & automask_en_i & irq_o;

  always_comb begin
    cause_clr = '0;
    if (rd_ok && addr_i == A_CAUSE)        cause_clr = '1;
    else if (wr_en_i && addr_i == A_CAUSE) cause_clr = wdata_i[NUM_CAUSE-1:0];
  end

  assign mask_set = (wr_en_i && addr_i == A_MSET) ? wdata_i[NUM_CAUSE-1:0] : '0;
  assign mask_clr = ((wr_en_i && addr_i == A_MCLR) ? wdata_i[NUM_CAUSE-1:0] : '0)
                  | (auto_fire ? am_q[NUM_CAUSE-1:0] : '0);

  irq_cause_reg #(.NUM_CAUSE(NUM_CAUSE)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(event_i), .clr_i(cause_clr), .cause_o(cause_q)
  );

  irq_mask_reg #(.NUM_CAUSE(NUM_CAUSE)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(mask_set), .clr_i(mask_clr), .mask_o(mask_q)
  );

  irq_word_reg #(.W(DW)) u_amask (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i && addr_i == A_AMASK),
    .d_i(wdata_i), .q_o(am_q)
  );

  assign irq_o = |(cause_q & mask_q);

  always_comb begin
    cause_word                = '0;
    cause_word[NUM_CAUSE-1:0] = cause_q;
    cause_word[DW-1]          = irq_o;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_CAUSE:        rdata_o = cause_word;
        A_MSET, A_MCLR: rdata_o = DW'(mask_q);
        A_AMASK:        rdata_o = am_q;
        default:        rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_cause_unit_chk.sv
module irq_cause_unit_chk #(
  parameter int unsigned NUM_CAUSE = 31,
  parameter int unsigned ADDR_W    = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CAUSE-1:0] event_i,
  input logic                 automask_en_i,
  input logic                 rd_en_i,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          wdata_i,
  input logic                 irq_o,
  input logic [NUM_CAUSE-1:0] cause_q,
  input logic [NUM_CAUSE-1:0] mask_q,
  input logic [31:0]          am_q
);
  logic at_cause, at_mset;
  assign at_cause = (addr_i == ADDR_W'(irq_pkg::OFS_CAUSE));
  assign at_mset  = (addr_i == ADDR_W'(irq_pkg::OFS_MSET));

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((cause_q & $past(event_i)) == $past(event_i)));

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && at_cause && event_i == '0) |=> (cause_q == '0));

  a_r4_irq_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cause_q != '0 && mask_q != '0));

  a_r5_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && at_mset) |=>
      ((mask_q & $past(wdata_i[NUM_CAUSE-1:0])) == $past(wdata_i[NUM_CAUSE-1:0])));

  a_r7_automask_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i || wr_en_i) && at_cause && automask_en_i && irq_o) |=>
      ((mask_q & $past(am_q[NUM_CAUSE-1:0])) == '0));

  a_r8_mask_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i || wr_en_i) && at_cause && !(automask_en_i && irq_o)) |=>
      (mask_q == $past(mask_q)));
endmodule

bind irq_cause_unit irq_cause_unit_chk #(.NUM_CAUSE(NUM_CAUSE), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .event_i(event_i), .automask_en_i(automask_en_i),
  .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .irq_o(irq_o), .cause_q(cause_q), .mask_q(mask_q), .am_q(am_q)
);

// File: tb/sim_irq_cause_unit.sv
`timescale 1ns/1ps
module sim_irq_cause_unit;
  localparam int unsigned NC = 31;
  localparam int unsigned AW = 4;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic [NC-1:0] event_i = '0;
  logic          automask_en_i = 1'b0, rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0, rdata_o;
  logic          irq_o;
  int            n_chk = 0, n_bad = 0;
  logic          done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_cause_unit #(.NUM_CAUSE(NC), .ADDR_W(AW)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = AW'(a);
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [NC-1:0] e);
    @(negedge clk_i);
    event_i = e;
    @(negedge clk_i);
    event_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(1, d); check("R1 mask", d, 32'h0);
    rd(3, d); check("R1 amask", d, 32'h0);
    rd(0, d); check("R1 cause", d, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    pulse(NC'(32'h88));
    rd(0, d); check("R2 cause set", d, 32'h88);
    rd(0, d); check("R3 read clears", d, 32'h0);
    pulse(NC'(32'h6));
    wr(0, 32'h2);
    rd(0, d); check("R3 w1c", d, 32'h4);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(1, 32'h0F);
    wr(1, 32'h00);
    rd(1, d); check("R5 set/0 no effect", d, 32'h0F);
    wr(2, 32'h03);
    rd(2, d); check("R5 clear", d, 32'h0C);
    wr(2, 32'h00);
    rd(1, d); check("R5 clear 0 no effect", d, 32'h0C);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    pulse(NC'(32'h20));
    check("R4 unmasked cause no irq", {31'b0, irq_o}, 32'h0);
    rd(0, d); check("R4 cause word low flag", d, 32'h20);
    pulse(NC'(32'h4));
    check("R4 irq high", {31'b0, irq_o}, 32'h1);
    rd(0, d); check("R4 flag in bit31", d, 32'h8000_0004);
    check("R4 irq drops after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_amask_reg;
    logic [31:0] d;
    wr(3, 32'hFFFF_0008);
    rd(3, d); check("R6 amask readback", d, 32'hFFFF_0008);
  endtask

  task automatic t_automask;
    logic [31:0] d;
    automask_en_i = 1'b1;
    pulse(NC'(32'h4));
    wr(0, 32'h0);
    rd(1, d); check("R7 write trigger", d, 32'h04);
    check("R7 irq kept", {31'b0, irq_o}, 32'h1);
    wr(3, 32'h4);
    rd(0, d); check("R7 read returns", d, 32'h8000_0004);
    rd(1, d); check("R7 read trigger", d, 32'h0);
    automask_en_i = 1'b0;
  endtask

  task automatic t_no_automask;
    logic [31:0] d;
    wr(1, 32'h0C); wr(3, 32'h0C);
    pulse(NC'(32'h4));
    rd(0, d);
    rd(1, d); check("R8 enable low", d, 32'h0C);
    automask_en_i = 1'b1;
    pulse(NC'(32'h20));
    rd(0, d);
    rd(1, d); check("R8 irq low", d, 32'h0C);
    automask_en_i = 1'b0;
  endtask

  task automatic t_collide;
    logic [31:0] d;
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = AW'(0); event_i = NC'(32'h10);
    @(negedge clk_i);
    rd_en_i = 1'b0; event_i = '0;
    rd(0, d); check("R9 event beats read clear", d, 32'h10 | 32'h8000_0000 & 32'h0);
    pulse(NC'(32'h1));
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = AW'(0); wdata_i = 32'h1; event_i = NC'(32'h1);
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0; event_i = '0;
    rd(0, d); check("R9 event beats w1c", d, 32'h1);
  endtask

  task automatic t_both_strobes;
    logic [31:0] d;
    pulse(NC'(32'h40));
    @(negedge clk_i);
    wr_en_i = 1'b1; rd_en_i = 1'b1; addr_i = AW'(0); wdata_i = 32'h0;
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    rd(0, d); check("R10 read ignored", d, 32'h40);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_events();
    t_mask();
    t_irq();
    t_amask_reg();
    t_automask();
    t_no_automask();
    t_collide();
    t_both_strobes();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule